// File: doc/BRIEF.md
# Bus Write Injector with Three-State Drive

This block sits next to a frame receiver for a serial model-railway control bus and injects host writes onto that bus. It reads the receiver's decoding position: phase, address-field slot, base address, frame index and bit slot. It reads the byte the receiver currently holds for the channel under decode, and from these it decides, slot by slot, whether to drive the shared data line and to what level. A host can request that one byte be written to one channel. It can also request a one-shot level for the track-power bit that leads every address field.

The decision is taken once per bus bit, on the falling edge of the bus clock, so that the driven level is settled long before the next rising edge on which every bus node samples. The bus clock is brought into the system clock domain through a synchroniser, and its falling edge becomes a single-cycle strobe. The block only drives data bits that differ from the value already held for the channel, and it releases the line in every other slot. The line is driven through two active-low control lines, one for the high-side stage and one for the low-side stage, which together encode drive-0, drive-1 and release.

Top module: `bus_wr_injector`

## Requirements
- R1: After reset both drive lines are 1 (line released), busy is 0, reject is 0 and no track-bit request is pending.
- R2: A write request while busy is 0 latches channel and data and sets busy in the next cycle. A request while busy is 1 pulses reject for one cycle and leaves the latched channel and data unchanged.
- R3: The drive lines change only in the cycle after a detected falling edge of the bus clock. The falling edge is seen SYNC_STAGES+1 system cycles after the bus clock input falls.
- R4: In the data phase (phase code 2) the channel under decode is (NUM_BASES−1−base) + NUM_BASES·(NUM_FRAMES−1−frame). Data may be driven only when busy is 1 and this channel equals the latched channel.
- R5: Data bits D0..D7 occupy bit slots 0,1,3,4,6,7,9,10 in that order. In a matching frame a data slot drives the requested bit only when it differs from the same bit of the stored byte; otherwise the line is released.
- R6: Bit slots 2, 5 and 8 release the line. Slot 11 of a matching frame releases the line and clears busy.
- R7: In the address phase (phase code 1), address slot 0 drives the pending track-bit value if one is pending, else releases. Address slot 1 releases the line and clears the pending request.
- R8: A track-bit request with value 0 or 1 replaces any pending one; values 2 and 3 are ignored. A request arriving in the same cycle as the slot-1 clear is kept.
- R9: Drive-0 is high-side line 1 and low-side line 0; drive-1 is high-side 0 and low-side 1; release is both 1. Both lines are never 0 together.
- R10: In the hunt phase (phase code 0) and in every other address slot, the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Bus clock, asynchronous to clk |
| rx_phase_i | input | 2 | Receiver phase: 0 hunt, 1 address, 2 data |
| rx_addr_slot_i | input | 3 | Receiver slot within the address field |
| rx_base_i | input | BASE_W | Receiver base address |
| rx_frame_i | input | FRAME_W | Receiver frame index within the data field |
| rx_slot_i | input | 4 | Receiver bit slot within a data frame |
| tbl_chan_o | output | CHAN_W | Channel whose stored byte is looked up |
| tbl_byte_i | input | 8 | Stored byte for tbl_chan_o |
| wr_req_i | input | 1 | Host write request strobe |
| wr_chan_i | input | CHAN_W | Channel to write |
| wr_data_i | input | 8 | Byte to write |
| wr_busy_o | output | 1 | A write is pending |
| wr_reject_o | output | 1 | One-cycle pulse: request refused |
| trk_req_i | input | 1 | Track-bit request strobe |
| trk_val_i | input | 2 | Track-bit value; only 0 and 1 accepted |
| drv_hi_n_o | output | 1 | High-side drive, active low |
| drv_lo_n_o | output | 1 | Low-side drive, active low |

## Verification
The bench builds the block with its defaults: 16 bases, 7 frames and a two-stage synchroniser. This gives 112 reachable channels, and the test's channel 76 (base 3, frame 2) and channel 60 (base 3, frame 3) both fall inside that range. With SYNC_STAGES at 2, the behavioural model's edge history is four entries deep, so the three-cycle lag from bus clock fall to output change is exercised on every bit. Walking all twelve slots of one matching frame reaches every data-slot mapping, every separator and the busy clear.

// File: rtl/inj_pkg.sv
package inj_pkg;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_RSVD = 2'd3
  } rx_phase_t;

  typedef enum logic [1:0] {
    DRV_REL  = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_HIGH = 2'd2
  } drv_t;

  localparam int unsigned SLOT_W     = 4;
  localparam int unsigned ASLOT_W    = 3;
  localparam int unsigned LAST_SLOT  = 11;

  // Bit slots come in groups of three: two data bits then one separator.
  // Returns {is_data, bit_index}.
  function automatic logic [3:0] slot_decode(input logic [SLOT_W-1:0] slot);
    logic [3:0] grp;
    logic [3:0] pos;
    logic       is_data;
    logic [2:0] idx;
    grp     = slot / 4'd3;
    pos     = slot % 4'd3;
    is_data = (slot < 4'd11) && (pos != 4'd2);
    idx     = 3'(grp * 4'd2 + pos);
    return {is_data, idx};
  endfunction

endpackage

// File: rtl/inj_fall_det.sv
module inj_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    chain_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
    prev_d = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/inj_host_regs.sv
module inj_host_regs #(
  parameter int unsigned CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req_i,
  input  logic [CHAN_W-1:0] wr_chan_i,
  input  logic [7:0]        wr_data_i,
  input  logic              trk_req_i,
  input  logic [1:0]        trk_val_i,
  input  logic              busy_clr_i,
  input  logic              trk_clr_i,
  output logic              busy_o,
  output logic              reject_o,
  output logic [CHAN_W-1:0] req_chan_o,
  output logic [7:0]        req_data_o,
  output logic              trk_pend_o,
  output logic              trk_bit_o
);

  logic              busy_q, busy_d;
  logic              rej_q, rej_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [7:0]        data_q, data_d;
  logic              pend_q, pend_d;
  logic              tbit_q, tbit_d;
  logic              wr_take;
  logic              trk_take;

  assign wr_take  = wr_req_i & ~busy_q;
  assign trk_take = trk_req_i & ~trk_val_i[1];

  always_comb begin
    busy_d = busy_q;
    chan_d = chan_q;
    data_d = data_q;
    if (busy_clr_i) begin
      busy_d = 1'b0;
    end
    if (wr_take) begin
      busy_d = 1'b1;
      chan_d = wr_chan_i;
      data_d = wr_data_i;
    end
    rej_d = wr_req_i & busy_q;
  end

  always_comb begin
    pend_d = pend_q;
    tbit_d = tbit_q;
    if (trk_clr_i) begin
      pend_d = 1'b0;
    end
    if (trk_take) begin
      pend_d = 1'b1;
      tbit_d = trk_val_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rej_q  <= 1'b0;
      chan_q <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
      tbit_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rej_q  <= rej_d;
      chan_q <= chan_d;
      data_q <= data_d;
      pend_q <= pend_d;
      tbit_q <= tbit_d;
    end
  end

  assign busy_o     = busy_q;
  assign reject_o   = rej_q;
  assign req_chan_o = chan_q;
  assign req_data_o = data_q;
  assign trk_pend_o = pend_q;
  assign trk_bit_o  = tbit_q;

endmodule

// File: rtl/inj_drive_sel.sv
module inj_drive_sel
  import inj_pkg::*;
#(
  parameter int unsigned NUM_BASES  = 16,
  parameter int unsigned NUM_FRAMES = 7,
  parameter int unsigned BASE_W     = 4,
  parameter int unsigned FRAME_W    = 3,
  parameter int unsigned CHAN_W     = 7
) (
  input  logic [1:0]         phase_i,
  input  logic [ASLOT_W-1:0] addr_slot_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [7:0]         tbl_byte_i,
  input  logic               busy_i,
  input  logic [CHAN_W-1:0]  req_chan_i,
  input  logic [7:0]         req_data_i,
  input  logic               trk_pend_i,
  input  logic               trk_bit_i,
  output logic [CHAN_W-1:0]  cur_chan_o,
  output drv_t               code_o,
  output logic               busy_hit_o,
  output logic               trk_hit_o
);

  int         chan_int;
  logic       hit;
  logic [3:0] dec;
  logic       want_bit;
  logic       held_bit;

  always_comb begin
    chan_int   = (int'(NUM_BASES) - 1 - int'(base_i))
               + int'(NUM_BASES) * (int'(NUM_FRAMES) - 1 - int'(frame_i));
    cur_chan_o = CHAN_W'(chan_int);
  end

  assign hit      = busy_i && (cur_chan_o == req_chan_i);
  assign dec      = slot_decode(slot_i);
  assign want_bit = req_data_i[dec[2:0]];
  assign held_bit = tbl_byte_i[dec[2:0]];

  always_comb begin
    code_o = DRV_REL;
    unique case (phase_i)
      PH_ADDR: begin
        if ((addr_slot_i == '0) && trk_pend_i) begin
          code_o = trk_bit_i ? DRV_HIGH : DRV_LOW;
        end
      end
      PH_DATA: begin
        if (hit && dec[3] && (want_bit != held_bit)) begin
          code_o = want_bit ? DRV_HIGH : DRV_LOW;
        end
      end
      default: code_o = DRV_REL;
    endcase
  end

  assign busy_hit_o = (phase_i == PH_DATA) && hit
                    && (slot_i == SLOT_W'(LAST_SLOT));
  assign trk_hit_o  = (phase_i == PH_ADDR) && (addr_slot_i == ASLOT_W'(1));

endmodule

// File: rtl/inj_out_stage.sv
module inj_out_stage
  import inj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  drv_t code_i,
  output logic hi_n_o,
  output logic lo_n_o
);

  logic hi_enc, lo_enc;
  logic hi_d, lo_d;
  logic hi_q, lo_q;

  always_comb begin
    unique case (code_i)
      DRV_LOW:  begin hi_enc = 1'b1; lo_enc = 1'b0; end
      DRV_HIGH: begin hi_enc = 1'b0; lo_enc = 1'b1; end
      default:  begin hi_enc = 1'b1; lo_enc = 1'b1; end
    endcase
  end

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (stb_i) begin
      hi_d = hi_enc;
      lo_d = lo_enc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b1;
      lo_q <= 1'b1;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_n_o = hi_q;
  assign lo_n_o = lo_q;

endmodule

// File: rtl/bus_wr_injector.sv
module bus_wr_injector
  import inj_pkg::*;
#(
  parameter int unsigned NUM_BASES   = 16,
  parameter int unsigned NUM_FRAMES  = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BASE_W     = $clog2(NUM_BASES),
  localparam int unsigned FRAME_W    = $clog2(NUM_FRAMES),
  localparam int unsigned CHAN_W     = $clog2(NUM_BASES * NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_clk_i,
  input  logic [1:0]         rx_phase_i,
  input  logic [2:0]         rx_addr_slot_i,
  input  logic [BASE_W-1:0]  rx_base_i,
  input  logic [FRAME_W-1:0] rx_frame_i,
  input  logic [3:0]         rx_slot_i,
  output logic [CHAN_W-1:0]  tbl_chan_o,
  input  logic [7:0]         tbl_byte_i,
  input  logic               wr_req_i,
  input  logic [CHAN_W-1:0]  wr_chan_i,
  input  logic [7:0]         wr_data_i,
  output logic               wr_busy_o,
  output logic               wr_reject_o,
  input  logic               trk_req_i,
  input  logic [1:0]         trk_val_i,
  output logic               drv_hi_n_o,
  output logic               drv_lo_n_o
);

  logic              rst_meta_q, rst_sync_q;
  logic              fall_stb;
  logic              busy_hit, trk_hit;
  logic              req_busy;
  logic [CHAN_W-1:0] req_chan;
  logic [7:0]        req_data;
  logic              trk_pend, trk_bit;
  drv_t              drv_code;

  // reset: asserted at once, released after two clean clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  inj_fall_det #(
    .STAGES (SYNC_STAGES)
  ) u_fall (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (bus_clk_i),
    .fall_o  (fall_stb)
  );

  inj_host_regs #(
    .CHAN_W (CHAN_W)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_req_i   (wr_req_i),
    .wr_chan_i  (wr_chan_i),
    .wr_data_i  (wr_data_i),
    .trk_req_i  (trk_req_i),
    .trk_val_i  (trk_val_i),
    .busy_clr_i (fall_stb & busy_hit),
    .trk_clr_i  (fall_stb & trk_hit),
    .busy_o     (req_busy),
    .reject_o   (wr_reject_o),
    .req_chan_o (req_chan),
    .req_data_o (req_data),
    .trk_pend_o (trk_pend),
    .trk_bit_o  (trk_bit)
  );

  inj_drive_sel #(
    .NUM_BASES  (NUM_BASES),
    .NUM_FRAMES (NUM_FRAMES),
    .BASE_W     (BASE_W),
    .FRAME_W    (FRAME_W),
    .CHAN_W     (CHAN_W)
  ) u_sel (
    .phase_i     (rx_phase_i),
    .addr_slot_i (rx_addr_slot_i),
    .base_i      (rx_base_i),
    .frame_i     (rx_frame_i),
    .slot_i      (rx_slot_i),
    .tbl_byte_i  (tbl_byte_i),
    .busy_i      (req_busy),
    .req_chan_i  (req_chan),
    .req_data_i  (req_data),
    .trk_pend_i  (trk_pend),
    .trk_bit_i   (trk_bit),
    .cur_chan_o  (tbl_chan_o),
    .code_o      (drv_code),
    .busy_hit_o  (busy_hit),
    .trk_hit_o   (trk_hit)
  );

  inj_out_stage u_out (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .stb_i  (fall_stb),
    .code_i (drv_code),
    .hi_n_o (drv_hi_n_o),
    .lo_n_o (drv_lo_n_o)
  );

  assign wr_busy_o = req_busy;

endmodule

// File: rtl/bus_wr_injector_chk.sv
module bus_wr_injector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stb,
  input logic [1:0] phase,
  input logic [3:0] slot,
  input logic       busy,
  input logic       reject,
  input logic       wr_req,
  input logic       hi_n,
  input logic       lo_n
);

  // R9
  lines_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_n || lo_n));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb) |-> $stable({hi_n, lo_n}));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_req));

  // R2
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $past(wr_req && busy));

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(stb));

  // R6
  separator_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && phase == 2'd2 && (slot == 4'd2 || slot == 4'd5 || slot == 4'd8))
    |=> (hi_n && lo_n));

  // R10
  hunt_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && phase == 2'd0) |=> (hi_n && lo_n));

endmodule

bind bus_wr_injector bus_wr_injector_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .stb    (fall_stb),
  .phase  (rx_phase_i),
  .slot   (rx_slot_i),
  .busy   (wr_busy_o),
  .reject (wr_reject_o),
  .wr_req (wr_req_i),
  .hi_n   (drv_hi_n_o),
  .lo_n   (drv_lo_n_o)
);

// File: tb/test_bus_wr_injector.sv
`timescale 1ns/1ps
module test_bus_wr_injector;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0;
  logic [1:0] rx_phase = 2'd0;
  logic [2:0] rx_aslot = 3'd0;
  logic [3:0] rx_base = 4'd0;
  logic [2:0] rx_frame = 3'd0;
  logic [3:0] rx_slot = 4'd0;
  logic [6:0] tbl_chan;
  logic [7:0] tbl_byte;
  logic       wr_req = 1'b0;
  logic [6:0] wr_chan = 7'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_busy, wr_reject;
  logic       trk_req = 1'b0;
  logic [1:0] trk_val = 2'd0;
  logic       hi_n, lo_n;

  logic [7:0] tbl_mem [0:127];
  assign tbl_byte = tbl_mem[tbl_chan];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bus_wr_injector #(.SYNC_STAGES(SYNC)) i_bus_wr_injector (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk),
    .rx_phase_i(rx_phase), .rx_addr_slot_i(rx_aslot), .rx_base_i(rx_base),
    .rx_frame_i(rx_frame), .rx_slot_i(rx_slot),
    .tbl_chan_o(tbl_chan), .tbl_byte_i(tbl_byte),
    .wr_req_i(wr_req), .wr_chan_i(wr_chan), .wr_data_i(wr_data),
    .wr_busy_o(wr_busy), .wr_reject_o(wr_reject),
    .trk_req_i(trk_req), .trk_val_i(trk_val),
    .drv_hi_n_o(hi_n), .drv_lo_n_o(lo_n)
  );

  // ---------------- behavioural reference ----------------
  bit   hist[$];
  bit   m_hi, m_lo, m_busy, m_rej, m_pend, m_tval;
  int   m_chan;
  bit [7:0] m_data;
  int   bitpos [12] = '{0, 1, -1, 2, 3, -1, 4, 5, -1, 6, 7, -1};

  always @(posedge clk or negedge rst_n) begin
    bit stb, nb, np;
    int want, ch, bp;
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < SYNC + 2; i++) hist.push_back(1'b0);
      m_hi = 1; m_lo = 1; m_busy = 0; m_rej = 0; m_pend = 0; m_tval = 0;
      m_chan = 0; m_data = 0;
    end else begin
      hist.push_back(bus_clk);
      void'(hist.pop_front());
      stb = hist[0] && !hist[1];
      nb = m_busy;
      np = m_pend;
      if (stb) begin
        want = 2;
        if (rx_phase == 2'd1 && rx_aslot == 3'd0 && m_pend) want = int'(m_tval);
        if (rx_phase == 2'd2) begin
          ch = (15 - int'(rx_base)) + 16 * (6 - int'(rx_frame));
          if (m_busy && ch == m_chan) begin
            bp = (rx_slot < 12) ? bitpos[rx_slot] : -1;
            if (bp >= 0 && m_data[bp] != tbl_mem[ch][bp]) want = int'(m_data[bp]);
            if (rx_slot == 4'd11) nb = 0;
          end
        end
        m_hi = (want != 1);
        m_lo = (want != 0);
        if (rx_phase == 2'd1 && rx_aslot == 3'd1) np = 0;
      end
      m_rej = wr_req && m_busy;
      if (wr_req && !m_busy) begin
        nb = 1; m_chan = int'(wr_chan); m_data = wr_data;
      end
      if (trk_req && trk_val < 2) begin
        np = 1; m_tval = trk_val[0];
      end
      m_busy = nb;
      m_pend = np;
    end
  end

  // R3: every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({hi_n, lo_n, wr_busy, wr_reject} !== {m_hi, m_lo, m_busy, m_rej}) begin
        errors++;
        $display("FAIL R3 cycle %0d: hi/lo/busy/rej actual %b%b%b%b expected %b%b%b%b",
                 cyc, hi_n, lo_n, wr_busy, wr_reject, m_hi, m_lo, m_busy, m_rej);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_bit(input logic [1:0] ph, input int aslot, input int base,
                         input int frame, input int slot);
    @(negedge clk);
    rx_phase = ph; rx_aslot = 3'(aslot); rx_base = 4'(base);
    rx_frame = 3'(frame); rx_slot = 4'(slot); bus_clk = 1'b1;
    repeat (6) @(negedge clk);
    bus_clk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_write(input int ch, input logic [7:0] d);
    @(negedge clk);
    wr_req = 1'b1; wr_chan = 7'(ch); wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic set_trk(input logic [1:0] v);
    @(negedge clk);
    trk_req = 1'b1; trk_val = v;
    @(negedge clk);
    trk_req = 1'b0;
  endtask

  // line code: 0 drive-0, 1 drive-1, 2 released (R9 encoding)
  function automatic int line_code();
    if (hi_n && lo_n) return 2;
    if (hi_n && !lo_n) return 0;
    if (!hi_n && lo_n) return 1;
    return 3;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_code;
    for (int i = 0; i < 128; i++) tbl_mem[i] = 8'((i * 3) ^ 8'h5C);
    tbl_mem[76] = 8'hA5;
    tbl_mem[60] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    check("R1 hi_n", hi_n, 1);
    check("R1 lo_n", lo_n, 1);
    check("R1 busy", wr_busy, 0);
    check("R1 reject", wr_reject, 0);

    // R10 hunt phase releases
    bus_bit(2'd0, 0, 0, 0, 0);
    check("R10 hunt", line_code(), 2);

    // R8 illegal value ignored, R1 nothing pending at start
    set_trk(2'd2);
    bus_bit(2'd1, 0, 0, 0, 0);
    check("R8 ignored value", line_code(), 2);

    // R8 overwrite, R7 drive at slot 0, R9 encoding of drive-1
    set_trk(2'd0);
    set_trk(2'd1);
    bus_bit(2'd1, 0, 0, 0, 0);
    check("R7 R9 track drive-1", line_code(), 1);
    bus_bit(2'd1, 1, 0, 0, 0);
    check("R7 slot1 release", line_code(), 2);
    for (int a = 2; a < 8; a++) begin
      bus_bit(2'd1, a, 0, 0, 0);
      check("R10 other addr slot", line_code(), 2);
    end
    bus_bit(2'd1, 0, 0, 0, 0);
    check("R7 cleared after slot1", line_code(), 2);

    // R9 encoding of drive-0
    set_trk(2'd0);
    bus_bit(2'd1, 0, 0, 0, 0);
    check("R9 track drive-0 hi", hi_n, 1);
    check("R9 track drive-0 lo", lo_n, 0);
    bus_bit(2'd1, 1, 0, 0, 0);

    // R2 accept, then reject while busy
    host_write(76, 8'hA6);
    check("R2 busy set", wr_busy, 1);
    host_write(76, 8'h00);
    check("R2 reject pulse", wr_reject, 1);
    check("R2 still busy", wr_busy, 1);
    @(negedge clk);
    check("R2 reject one cycle", wr_reject, 0);

    // R4 non-matching channel (base 3, frame 3 -> 60) stays released
    bus_bit(2'd2, 0, 3, 3, 0);
    check("R4 other channel", line_code(), 2);

    // R4 R5 R6 matching frame: base 3, frame 2 -> channel 76
    for (int s = 0; s < 12; s++) begin
      bus_bit(2'd2, 0, 3, 2, s);
      exp_code = 2;
      if (bitpos[s] >= 0 && (8'hA6 >> bitpos[s]) % 2 != (8'hA5 >> bitpos[s]) % 2)
        exp_code = (8'hA6 >> bitpos[s]) % 2;
      if (bitpos[s] >= 0) check("R5 data slot", line_code(), exp_code);
      else                check("R6 separator/end slot", line_code(), 2);
    end
    check("R6 busy cleared", wr_busy, 0);

    // R2 new write accepted after clear; R10 hunt while busy
    host_write(76, 8'h5A);
    check("R2 accept after clear", wr_busy, 1);
    bus_bit(2'd0, 0, 3, 2, 0);
    check("R10 hunt while busy", line_code(), 2);
    bus_bit(2'd2, 0, 3, 2, 3);
    check("R5 D2 drive-0", line_code(), 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule